// File: doc/BRIEF.md
# Serial EEPROM Random-Read Controller

This block is the master side of a two-wire serial bus. It fetches one byte from a serial EEPROM at any byte address. A single start strobe launches the sequence. The sequence has several parts:

- An opening START condition and a device byte with the write direction.
- One or two address bytes.
- A repeated START and the device byte again, this time with the read direction.
- Eight data bits clocked in from the memory, followed by a not-acknowledge from the master and a STOP.

A mode input selects the addressing style for each access:

- **Small parts (one address byte):** address bits 10..8 go into the three select bits of the device byte.
- **Large parts (two address bytes):** those select bits are zero, and two address bytes follow.

The sequence stops early if the memory leaves any device or address byte unacknowledged. In that case the block still closes the bus with a STOP, then reports completion with the error flag set.

Both bus lines are open-drain. The block only drives a line low or leaves it released. The serial clock rate comes from a divider input. Each bit takes four equal phases of `quarter_div`+1 system clock cycles.

Top module: `eeprom_rd_master`

## Requirements
- R1: The first byte after the opening START is sent most significant bit first as {1010, sel[2:0], 0}. With `two_byte`=0, sel is `addr[10:8]`.
- R2: With `two_byte`=1, sel is 000. Two address bytes follow: `addr[15:8]` first, then `addr[7:0]`.
- R3: With `two_byte`=0, exactly one address byte, `addr[7:0]`, follows the device byte.
- R4: After the address bytes a repeated START is issued, then the device byte {1010, sel, 1} with the same sel.
- R5: After the read device byte is acknowledged, eight bits are read MSB first. The master then leaves SDA released (high) on the ninth clock as a not-acknowledge, and issues a STOP. `rdata` takes the byte and `err` reads 0 at `done`.
- R6: If any device or address byte sees SDA high in its acknowledge clock, no further byte is sent and a STOP follows. `done` then comes with `err`=1, and `rdata` keeps its previous value.
- R7: `busy` rises the cycle after an accepted `start`. `done` is a one-cycle pulse in the first cycle that `busy` is low again. `err` and `rdata` change only with `done`.
- R8: A `start` pulse while `busy` is high is ignored. The running access completes unchanged with a single `done`.
- R9: After reset, `busy`, `done`, `err` and `rdata` are 0. While idle, both line enables are 0 (lines released).
- R10: Every SCL high time lasts 2*(`quarter_div`+1) system clock cycles.
- R11: SDA changes while SCL is high only for START and STOP. A successful access shows exactly two STARTs and one STOP. An aborted one shows one STOP and only the STARTs issued before the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, accepted only while idle |
| two_byte | input | 1 | 1: two address bytes, 0: one address byte with high bits in sel |
| addr | input | 16 | Byte address (bits 15..11 unused in one-byte mode) |
| quarter_div | input | DIV_W | Cycles per SCL quarter phase, minus one |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read successfully |
| err | output | 1 | Missing acknowledge in the last access |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The hardest situation to reach is an acknowledge missing on the read device byte that follows the repeated START. At that point the address phase has fully succeeded, so the abort must come after two STARTs while `rdata` stays unchanged. The bench's bus-level memory model counts the received bytes across both STARTs. Each table row names the byte index the model refuses to acknowledge, so that one row lands the refusal exactly on that read device byte in each addressing mode. Other rows land it on the write device byte and on an address byte.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

    localparam int ADDR_W = 16;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    // Bit-level operations of the bus engine; each spans four quarter phases.
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WBIT  = 2'd2,
        OP_RBIT  = 2'd3
    } bus_op_e;

    // Pull-low requests for the two open-drain lines.
    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drv_t;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_START = 3'd1,
        SQ_TX    = 3'd2,
        SQ_RX    = 3'd3,
        SQ_STOP  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        BY_CTRL_W  = 2'd0,
        BY_ADDR_HI = 2'd1,
        BY_ADDR_LO = 2'd2,
        BY_CTRL_R  = 2'd3
    } byte_kind_e;

    // Line levels per operation and quarter phase. SDA moves only in
    // phases where SCL is held low, except for the START/STOP edges.
    function automatic line_drv_t drive_for(bus_op_e op, logic [1:0] q, logic b);
        line_drv_t d;
        case (op)
            OP_START: begin
                d.scl_low = (q == 2'd0) || (q == 2'd3);
                d.sda_low = (q >= 2'd2);
            end
            OP_STOP: begin
                d.scl_low = (q == 2'd0);
                d.sda_low = (q <= 2'd1);
            end
            OP_WBIT: begin
                d.scl_low = (q == 2'd0) || (q == 2'd3);
                d.sda_low = ~b;
            end
            default: begin
                d.scl_low = (q == 2'd0) || (q == 2'd3);
                d.sda_low = 1'b0;
            end
        endcase
        return d;
    endfunction

    function automatic logic [2:0] sel_bits(logic two, logic [ADDR_W-1:0] a);
        return two ? 3'b000 : a[10:8];
    endfunction

    function automatic logic [7:0] ctrl_byte(logic [2:0] sel, logic rd);
        return {DEV_CODE, sel, rd};
    endfunction

endpackage

// File: rtl/eeprom_rd_tick.sv
module eeprom_rd_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == div);
endmodule

// File: rtl/eeprom_rd_bitengine.sv
module eeprom_rd_bitengine
    import eeprom_rd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_valid,
    input  bus_op_e cmd_op,
    input  logic    cmd_bit,
    input  logic    tick,
    input  logic    sda_s,
    output logic    ready,
    output logic    active,
    output logic    done,
    output logic    rx_bit,
    output logic    scl_oe,
    output logic    sda_oe
);
    logic      active_q;
    bus_op_e   op_q;
    logic      bit_q;
    logic [1:0] q_q;
    line_drv_t drv_q;
    logic      done_q;
    logic      rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            op_q     <= OP_STOP;
            bit_q    <= 1'b0;
            q_q      <= 2'd0;
            drv_q    <= '0;
            done_q   <= 1'b0;
            rx_q     <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (cmd_valid) begin
                    active_q <= 1'b1;
                    op_q     <= cmd_op;
                    bit_q    <= cmd_bit;
                    q_q      <= 2'd0;
                    drv_q    <= drive_for(cmd_op, 2'd0, cmd_bit);
                end
            end else if (tick) begin
                // sample in the middle of the SCL high time
                if (q_q == 2'd1 && op_q == OP_RBIT) begin
                    rx_q <= sda_s;
                end
                if (q_q == 2'd3) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    q_q   <= q_q + 2'd1;
                    drv_q <= drive_for(op_q, q_q + 2'd1, bit_q);
                end
            end
        end
    end

    assign ready  = !active_q;
    assign active = active_q;
    assign done   = done_q;
    assign rx_bit = rx_q;
    assign scl_oe = drv_q.scl_low;
    assign sda_oe = drv_q.sda_low;
endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
    import eeprom_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              two_byte,
    input  logic [ADDR_W-1:0] addr,
    input  logic              eng_ready,
    input  logic              eng_done,
    input  logic              eng_rx,
    output logic              cmd_valid,
    output bus_op_e           cmd_op,
    output logic              cmd_bit,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [7:0]        rdata
);
    seq_state_e        state_q;
    byte_kind_e        kind_q;
    logic [7:0]        sh_q;
    logic [3:0]        bitn_q;
    logic              issued_q;
    logic              rd_phase_q;
    logic              two_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        rx_q;
    logic              err_pend_q;
    logic              busy_q, done_q, err_q;
    logic [7:0]        rdata_q;
    logic [2:0]        sel;

    assign sel       = sel_bits(two_q, addr_q);
    assign cmd_valid = (state_q != SQ_IDLE) && !issued_q;

    always_comb begin
        cmd_op  = OP_STOP;
        cmd_bit = 1'b1;
        case (state_q)
            SQ_START: cmd_op = OP_START;
            SQ_TX: begin
                cmd_op  = (bitn_q == 4'd8) ? OP_RBIT : OP_WBIT;
                cmd_bit = sh_q[7];
            end
            SQ_RX: begin
                // eighth-plus-one clock: not-acknowledge, line left high
                cmd_op  = (bitn_q == 4'd8) ? OP_WBIT : OP_RBIT;
                cmd_bit = 1'b1;
            end
            default: cmd_op = OP_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            kind_q     <= BY_CTRL_W;
            sh_q       <= '0;
            bitn_q     <= '0;
            issued_q   <= 1'b0;
            rd_phase_q <= 1'b0;
            two_q      <= 1'b0;
            addr_q     <= '0;
            rx_q       <= '0;
            err_pend_q <= 1'b0;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            rdata_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == SQ_IDLE) begin
                if (start) begin
                    state_q    <= SQ_START;
                    busy_q     <= 1'b1;
                    two_q      <= two_byte;
                    addr_q     <= addr;
                    rd_phase_q <= 1'b0;
                    err_pend_q <= 1'b0;
                    issued_q   <= 1'b0;
                end
            end else if (cmd_valid && eng_ready) begin
                issued_q <= 1'b1;
            end else if (issued_q && eng_done) begin
                issued_q <= 1'b0;
                case (state_q)
                    SQ_START: begin
                        state_q <= SQ_TX;
                        bitn_q  <= '0;
                        sh_q    <= ctrl_byte(sel, rd_phase_q);
                        kind_q  <= rd_phase_q ? BY_CTRL_R : BY_CTRL_W;
                    end
                    SQ_TX: begin
                        if (bitn_q != 4'd8) begin
                            sh_q   <= {sh_q[6:0], 1'b0};
                            bitn_q <= bitn_q + 4'd1;
                        end else if (eng_rx) begin
                            err_pend_q <= 1'b1;
                            state_q    <= SQ_STOP;
                        end else begin
                            bitn_q <= '0;
                            case (kind_q)
                                BY_CTRL_W: begin
                                    kind_q <= two_q ? BY_ADDR_HI : BY_ADDR_LO;
                                    sh_q   <= two_q ? addr_q[15:8] : addr_q[7:0];
                                end
                                BY_ADDR_HI: begin
                                    kind_q <= BY_ADDR_LO;
                                    sh_q   <= addr_q[7:0];
                                end
                                BY_ADDR_LO: begin
                                    state_q    <= SQ_START;
                                    rd_phase_q <= 1'b1;
                                end
                                default: state_q <= SQ_RX;
                            endcase
                        end
                    end
                    SQ_RX: begin
                        if (bitn_q != 4'd8) begin
                            rx_q   <= {rx_q[6:0], eng_rx};
                            bitn_q <= bitn_q + 4'd1;
                        end else begin
                            state_q <= SQ_STOP;
                        end
                    end
                    default: begin
                        state_q <= SQ_IDLE;
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                        err_q   <= err_pend_q;
                        if (!err_pend_q) begin
                            rdata_q <= rx_q;
                        end
                    end
                endcase
            end
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign err   = err_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/eeprom_rd_master.sv
module eeprom_rd_master
    import eeprom_rd_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              two_byte,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DIV_W-1:0]  quarter_div,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rdata,
    output logic              err,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    logic             sda_s;
    logic [DIV_W-1:0] div_q;
    logic             tick, eng_ready, eng_active, eng_done, eng_rx;
    logic             cmd_valid, cmd_bit;
    bus_op_e          cmd_op;

    // input synchronizer for the sampled data line
    generate
        if (SYNC_STAGES <= 1) begin : g_sync1
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b1;
                else     s_q <= sda_in;
            end
            assign sda_s = s_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= '1;
                else     s_q <= {s_q[SYNC_STAGES-2:0], sda_in};
            end
            assign sda_s = s_q[SYNC_STAGES-1];
        end
    endgenerate

    // divider setting frozen for the whole access
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (start && !busy) begin
            div_q <= quarter_div;
        end
    end

    eeprom_rd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (eng_active),
        .div  (div_q),
        .tick (tick)
    );

    eeprom_rd_bitengine u_eng (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bit   (cmd_bit),
        .tick      (tick),
        .sda_s     (sda_s),
        .ready     (eng_ready),
        .active    (eng_active),
        .done      (eng_done),
        .rx_bit    (eng_rx),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    eeprom_rd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .two_byte  (two_byte),
        .addr      (addr),
        .eng_ready (eng_ready),
        .eng_done  (eng_done),
        .eng_rx    (eng_rx),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bit   (cmd_bit),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rdata     (rdata)
    );
endmodule

// File: rtl/eeprom_rd_chk.sv
module eeprom_rd_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [7:0] rdata,
    input logic       scl_oe,
    input logic       sda_oe
);
    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(err));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rdata));
endmodule

bind eeprom_rd_master eeprom_rd_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .rdata  (rdata),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe)
);

// File: tb/sim_eeprom_rd_master.sv
`timescale 1ns/1ps
module sim_eeprom_rd_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        two_byte = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  quarter_div = 8'd1;
    logic        busy, done, err, scl_oe, sda_oe;
    logic [7:0]  rdata;
    logic        scl_l, sda_l, slv_drv;

    always #2 clk = ~clk;

    assign scl_l = ~scl_oe;
    assign sda_l = ~(sda_oe | slv_drv);

    eeprom_rd_master u0 (
        .clk(clk), .rst(rst), .start(start), .two_byte(two_byte), .addr(addr),
        .quarter_div(quarter_div), .busy(busy), .done(done), .rdata(rdata),
        .err(err), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_l)
    );

    int n_chk = 0;
    int n_err = 0;

    function automatic logic [7:0] mem_of(logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hC6;
    endfunction

    // ---------------- bus-level memory model ----------------
    logic       slv_clr = 1'b1;
    logic       slv_two = 1'b0;
    logic [2:0] nack_at = 3'd7;
    logic       act, tx, tx_next, first, scl_p, sda_p, m_ack;
    logic [3:0] cn;
    logic [2:0] nb;
    logic [7:0] sh, txd, hi, hi_min, hi_max;
    logic [7:0] slog [8];
    int         n_start, n_stop, n_done;

    always @(negedge clk) begin
        if (slv_clr) begin
            act <= 0; tx <= 0; tx_next <= 0; first <= 0; cn <= 0; nb <= 0;
            slv_drv <= 0; m_ack <= 0; sh <= 0; txd <= 0;
            n_start <= 0; n_stop <= 0; n_done <= 0;
            hi <= 0; hi_min <= 8'hFF; hi_max <= 0;
            for (int i = 0; i < 8; i++) slog[i] <= 8'h00;
        end else begin
            if (done) n_done <= n_done + 1;
            if (scl_l && !scl_p) hi <= 8'd1;
            else if (scl_l && hi != 0) hi <= hi + 8'd1;
            if (!scl_l && scl_p && hi != 0) begin
                if (hi < hi_min) hi_min <= hi;
                if (hi > hi_max) hi_max <= hi;
            end
            if (scl_l && scl_p && sda_p && !sda_l) begin
                act <= 1; cn <= 0; tx <= 0; slv_drv <= 0; first <= 1;
                n_start <= n_start + 1;
            end else if (scl_l && scl_p && !sda_p && sda_l) begin
                act <= 0; tx <= 0; slv_drv <= 0; n_stop <= n_stop + 1;
            end else if (act && scl_l && !scl_p) begin
                if (cn < 8 && !tx) sh <= {sh[6:0], sda_l};
                if (cn == 8 && tx) m_ack <= sda_l;
                cn <= cn + 4'd1;
            end else if (act && !scl_l && scl_p) begin
                if (cn == 8) begin
                    if (!tx) begin
                        slog[nb] <= sh;
                        slv_drv  <= (nb != nack_at);
                        tx_next  <= (nb != nack_at) && first && sh[0];
                    end else begin
                        slv_drv <= 0;
                    end
                end else if (cn == 9) begin
                    cn <= 0; nb <= nb + 3'd1; first <= 0; slv_drv <= 0;
                    if (tx_next) begin
                        logic [15:0] ea;
                        ea = slv_two ? {slog[1], slog[2]}
                                     : {5'b0, slog[0][3:1], slog[1]};
                        tx <= 1; tx_next <= 0;
                        txd <= mem_of(ea);
                        slv_drv <= ~mem_of(ea)[7];
                    end
                end else if (tx && cn < 8) begin
                    slv_drv <= ~txd[3'd7 - cn[2:0]];
                end
            end
        end
        scl_p <= scl_l;
        sda_p <= sda_l;
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            $display("FAIL watchdog actual %0d expected <190000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk + 1, n_err + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act_v, exp_v);
        end
    endtask

    task automatic begin_txn(input logic two, input logic [15:0] a,
                             input logic [2:0] nk, input logic [7:0] dv);
        @(negedge clk);
        slv_clr = 1;
        @(negedge clk);
        slv_clr = 0;
        slv_two = two; nack_at = nk;
        two_byte = two; addr = a; quarter_div = dv;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        int w;
        w = 0;
        while (n_done == 0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 20000, "R7 done timeout", w, 20000);
        repeat (4) @(negedge clk);
    endtask

    // {two, addr, nack index (7 = none), quarter_div}
    localparam logic [23:0] VEC [8] = '{
        {1'b0, 16'h0523, 3'd7, 4'd1},
        {1'b1, 16'hBEEF, 3'd7, 4'd2},
        {1'b0, 16'h07FF, 3'd7, 4'd0},
        {1'b1, 16'h0000, 3'd7, 4'd3},
        {1'b0, 16'h0312, 3'd1, 4'd1},
        {1'b1, 16'h1234, 3'd3, 4'd1},
        {1'b1, 16'h4455, 3'd0, 4'd2},
        {1'b0, 16'h0601, 3'd2, 4'd1}
    };

    logic [7:0] exp_rd = 8'h00;

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state and released lines
        chk(busy == 0 && done == 0, "R9 reset busy/done", {busy, done}, 0);
        chk(err == 0 && rdata == 0, "R9 reset err/rdata", {err, rdata}, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R9 idle lines", {scl_oe, sda_oe}, 0);

        for (int v = 0; v < 8; v++) begin
            logic        t;
            logic [15:0] a;
            logic [2:0]  nk, sel;
            logic [7:0]  dv;
            logic [15:0] ea;
            bit          ok;
            int          ridx;
            {t, a, nk} = VEC[v][23:4];
            dv  = {4'd0, VEC[v][3:0]};
            sel = t ? 3'b000 : a[10:8];
            ea  = t ? a : {5'b0, a[10:8], a[7:0]};
            ok  = (nk == 3'd7);
            ridx = t ? 3 : 2;
            begin_txn(t, a, nk, dv);
            wait_done();
            // R1 / R2 write device byte
            chk(slog[0] == {4'b1010, sel, 1'b0}, t ? "R2 ctrl-w sel" : "R1 ctrl-w",
                slog[0], {4'b1010, sel, 1'b0});
            chk(err == !ok, "R6 err flag", err, !ok);
            chk(n_done == 1, "R7 single done", n_done, 1);
            // R11 start/stop conditions
            chk(n_stop == 1, "R11 stop count", n_stop, 1);
            chk(n_start == ((ok || nk == ridx[2:0]) ? 2 : 1), "R11 start count",
                n_start, (ok || nk == ridx[2:0]) ? 2 : 1);
            // R10 SCL high time
            chk(hi_min == 2 * (dv + 1) && hi_max == 2 * (dv + 1), "R10 scl high",
                {hi_min, hi_max}, 2 * (dv + 1));
            if (ok) begin
                exp_rd = mem_of(ea);
                if (t) begin
                    chk(slog[1] == a[15:8] && slog[2] == a[7:0], "R2 addr bytes",
                        {slog[1], slog[2]}, a);
                end else begin
                    chk(slog[1] == a[7:0], "R3 addr byte", slog[1], a[7:0]);
                end
                chk(slog[ridx] == {4'b1010, sel, 1'b1}, "R4 ctrl-r",
                    slog[ridx], {4'b1010, sel, 1'b1});
                chk(m_ack == 1, "R5 master nack", m_ack, 1);
            end
            // R5 / R6 data result
            chk(rdata == exp_rd, ok ? "R5 rdata" : "R6 rdata kept", rdata, exp_rd);
            chk(scl_oe == 0 && sda_oe == 0, "R9 lines released", {scl_oe, sda_oe}, 0);
        end

        // R8 start while busy is ignored
        begin_txn(1'b0, 16'h0456, 3'd7, 8'd1);
        repeat (40) @(negedge clk);
        chk(busy == 1, "R7 busy during access", busy, 1);
        two_byte = 1; addr = 16'h0789; start = 1;
        @(negedge clk);
        start = 0;
        wait_done();
        exp_rd = mem_of(16'h0456);
        chk(n_done == 1, "R8 one done", n_done, 1);
        chk(slog[0] == 8'hA8 && slog[1] == 8'h56, "R8 first access kept",
            {slog[0], slog[1]}, 16'hA856);
        chk(rdata == exp_rd && err == 0, "R8 rdata", rdata, exp_rd);
        chk(busy == 0, "R7 busy low after done", busy, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule